// File: doc/BRIEF.md
# Reversible Xor-Accumulate Execution Unit

This unit is the arithmetic and logic stage of a 12-bit processor in which every instruction must be undoable. Each cycle it may accept one decoded operation: a 5-bit opcode, the index and value of the destination register, the indices and values of two source registers (called A and B here), and a 9-bit immediate. One cycle later it presents the new destination value together with a write strobe, or it raises an illegal flag and writes nothing. It does not hold the register file, fetch instructions or resolve branches.

Operations that cannot be inverted on their own (AND, OR, shifts) never overwrite the destination. Their result is xor-folded into it instead, so running the same operation a second time restores the old value. A `reverse` input selects inverse execution. In that mode additions become subtractions and the two rotations trade places, while the xor forms are left unchanged. An operation whose source register is the same register as its destination would destroy information. The unit rejects such an operation, and it also rejects any opcode it does not know.

A small state machine sets the response. **IDLE** means no operation was accepted on the last edge. **COMMIT** means a legal operation was accepted and its result is being written. **REJECT** means an illegal operation was accepted and the write is suppressed. The next state depends only on the current input: with no valid input the machine goes to IDLE (transition *quiet*); with a legal operation it goes to COMMIT (*accept*); with an illegal one it goes to REJECT (*refuse*). Every state reaches every state.

Top module: `rxa_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `wr_en` and `illegal` are 0 and `wr_data` is 0.
- R2: A cycle with `in_valid`=1 produces exactly one of `wr_en`=1 or `illegal`=1 in the following cycle. A cycle with `in_valid`=0 produces neither in the following cycle.
- R3: ADD (01001) writes dst+B and ADDI (00001) writes dst+imm, both modulo 4096. With `reverse`=1 they write dst−B and dst−imm, modulo 4096.
- R4: The immediate is sign-extended by copying imm[8] into result bits 11..9.
- R5: XOR (01010) writes dst^B and XORI (00010) writes dst^imm, whatever the value of `reverse`.
- R6: ANDX (11000) writes dst^(A&B), ORX (11001) writes dst^(A|B), ANDIX (10000) writes dst^(A&imm) and ORIX (10001) writes dst^(A|imm), whatever the value of `reverse`.
- R7: RL (00100) rotates dst left by one (bit 11 goes to bit 0) and RR (00101) rotates it right by one (bit 0 goes to bit 11). With `reverse`=1 RL rotates right and RR rotates left.
- R8: SLLX (11100) writes dst^(A shifted left by one with 0 entering bit 0). SRAX (11110) writes dst^(A shifted right by one with bit 11 kept). Both ignore `reverse`.
- R9: For every legal operation, running it forward and then running it with `reverse`=1 on the forward result gives back the original destination value.
- R10: An operation that reads A with `a_idx`=`dst_idx` (ANDX, ORX, ANDIX, ORIX, SLLX, SRAX), or reads B with `b_idx`=`dst_idx` (ADD, XOR, ANDX, ORX), gives `illegal`=1 and `wr_en`=0.
- R11: Any opcode not listed above gives `illegal`=1 and `wr_en`=0.
- R12: `wr_idx` in the response cycle equals the `dst_idx` that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered this cycle |
| reverse | input | 1 | 1 = execute the inverse operation |
| opcode | input | 5 | Decoded operation code |
| dst_idx | input | 3 | Destination register index |
| a_idx | input | 3 | Source A register index |
| b_idx | input | 3 | Source B register index |
| dst_val | input | 12 | Current destination register value |
| a_val | input | 12 | Source A register value |
| b_val | input | 12 | Source B register value |
| imm | input | 9 | Signed immediate |
| wr_en | output | 1 | Write the destination register |
| wr_idx | output | 3 | Register to be written |
| wr_data | output | 12 | New destination value (0 unless `wr_en`) |
| illegal | output | 1 | The accepted operation was rejected |

## Verification
Every result is due exactly one clock edge after the operation is accepted. That single register stage holds both the state machine and the result, and the illegal flag follows the same timing. The bench drives an operation on a falling edge and removes it on the next falling edge. By then the rising edge in between has captured the operation, so it reads the response there, half a cycle after the edge that produced it. Idle-cycle checks read the outputs one further falling edge later, after a rising edge that saw no valid input.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
    localparam int unsigned OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_ADDI  = 5'b00001,
        OP_XORI  = 5'b00010,
        OP_RL    = 5'b00100,
        OP_RR    = 5'b00101,
        OP_ADD   = 5'b01001,
        OP_XOR   = 5'b01010,
        OP_ANDIX = 5'b10000,
        OP_ORIX  = 5'b10001,
        OP_ANDX  = 5'b11000,
        OP_ORX   = 5'b11001,
        OP_SLLX  = 5'b11100,
        OP_SRAX  = 5'b11110
    } rxa_op_e;

    typedef enum logic [2:0] {
        CL_BAD,
        CL_ARITH,
        CL_XOR,
        CL_ROT,
        CL_FOLD
    } rxa_class_e;

    typedef enum logic [1:0] {
        FN_AND,
        FN_OR,
        FN_SHL,
        FN_SRA
    } rxa_fold_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_REJECT
    } rxa_state_e;

    typedef struct packed {
        rxa_class_e cls;
        logic       use_imm;
        logic       rd_a;
        logic       rd_b;
        logic       subtract;
        logic       rot_left;
        rxa_fold_e  fn;
    } rxa_dec_t;
endpackage

// File: rtl/rxa_decode.sv
module rxa_decode
    import rxa_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic             reverse,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [IDX_W-1:0] b_idx,
    output rxa_dec_t         dec,
    output logic             illegal
);
    always_comb begin
        dec.cls      = CL_BAD;
        dec.use_imm  = 1'b0;
        dec.rd_a     = 1'b0;
        dec.rd_b     = 1'b0;
        dec.subtract = 1'b0;
        dec.rot_left = 1'b0;
        dec.fn       = FN_AND;
        case (opcode)
            OP_ADD: begin
                dec.cls      = CL_ARITH;
                dec.rd_b     = 1'b1;
                dec.subtract = reverse;
            end
            OP_ADDI: begin
                dec.cls      = CL_ARITH;
                dec.use_imm  = 1'b1;
                dec.subtract = reverse;
            end
            OP_XOR: begin
                dec.cls  = CL_XOR;
                dec.rd_b = 1'b1;
            end
            OP_XORI: begin
                dec.cls     = CL_XOR;
                dec.use_imm = 1'b1;
            end
            OP_RL: begin
                dec.cls      = CL_ROT;
                dec.rot_left = !reverse;
            end
            OP_RR: begin
                dec.cls      = CL_ROT;
                dec.rot_left = reverse;
            end
            OP_ANDX: begin
                dec.cls  = CL_FOLD;
                dec.rd_a = 1'b1;
                dec.rd_b = 1'b1;
                dec.fn   = FN_AND;
            end
            OP_ORX: begin
                dec.cls  = CL_FOLD;
                dec.rd_a = 1'b1;
                dec.rd_b = 1'b1;
                dec.fn   = FN_OR;
            end
            OP_ANDIX: begin
                dec.cls     = CL_FOLD;
                dec.rd_a    = 1'b1;
                dec.use_imm = 1'b1;
                dec.fn      = FN_AND;
            end
            OP_ORIX: begin
                dec.cls     = CL_FOLD;
                dec.rd_a    = 1'b1;
                dec.use_imm = 1'b1;
                dec.fn      = FN_OR;
            end
            OP_SLLX: begin
                dec.cls  = CL_FOLD;
                dec.rd_a = 1'b1;
                dec.fn   = FN_SHL;
            end
            OP_SRAX: begin
                dec.cls  = CL_FOLD;
                dec.rd_a = 1'b1;
                dec.fn   = FN_SRA;
            end
            default: ;
        endcase
        // an aliased source would erase the destination, so it is refused
        illegal = (dec.cls == CL_BAD)
                || (dec.rd_a && (a_idx == dst_idx))
                || (dec.rd_b && (b_idx == dst_idx));
    end
endmodule

// File: rtl/rxa_addsub.sv
module rxa_addsub #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] operand,
    input  logic         subtract,
    output logic [W-1:0] sum
);
    always_comb begin
        if (subtract) sum = base - operand;
        else          sum = base + operand;
    end
endmodule

// File: rtl/rxa_rotate.sv
module rxa_rotate #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] val,
    input  logic         left,
    output logic [W-1:0] rot
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int unsigned FROM_L = (i + W - 1) % W;
        localparam int unsigned FROM_R = (i + 1) % W;
        assign rot[i] = left ? val[FROM_L] : val[FROM_R];
    end
endmodule

// File: rtl/rxa_xfold.sv
module rxa_xfold
    import rxa_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_s,
    input  rxa_fold_e    fn,
    output logic [W-1:0] folded
);
    logic [W-1:0] term;

    always_comb begin
        unique case (fn)
            FN_AND:  term = src_a & src_s;
            FN_OR:   term = src_a | src_s;
            FN_SHL:  term = {src_a[W-2:0], 1'b0};
            FN_SRA:  term = {src_a[W-1], src_a[W-1:1]};
            default: term = '0;
        endcase
        folded = dst ^ term;
    end
endmodule

// File: rtl/rxa_unit.sv
module rxa_unit
    import rxa_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned IMM_W  = 9,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              reverse,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    input  logic [IMM_W-1:0]  imm,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              illegal
);
    localparam int unsigned EXT_W = DATA_W - IMM_W;

    rxa_dec_t    dec;
    logic        bad_op;
    logic [DATA_W-1:0] imm_ext, second, arith_out, rot_out, fold_out, nxt;
    rxa_state_e  state_q, state_d;
    logic [DATA_W-1:0] res_q;
    logic [IDX_W-1:0]  idx_q;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign second  = dec.use_imm ? imm_ext : b_val;

    rxa_decode #(.IDX_W(IDX_W)) u_decode (
        .opcode (opcode),
        .reverse(reverse),
        .dst_idx(dst_idx),
        .a_idx  (a_idx),
        .b_idx  (b_idx),
        .dec    (dec),
        .illegal(bad_op)
    );

    rxa_addsub #(.W(DATA_W)) u_addsub (
        .base    (dst_val),
        .operand (second),
        .subtract(dec.subtract),
        .sum     (arith_out)
    );

    rxa_rotate #(.W(DATA_W)) u_rotate (
        .val (dst_val),
        .left(dec.rot_left),
        .rot (rot_out)
    );

    rxa_xfold #(.W(DATA_W)) u_xfold (
        .dst   (dst_val),
        .src_a (a_val),
        .src_s (second),
        .fn    (dec.fn),
        .folded(fold_out)
    );

    always_comb begin
        unique case (dec.cls)
            CL_ARITH: nxt = arith_out;
            CL_XOR:   nxt = dst_val ^ second;
            CL_ROT:   nxt = rot_out;
            CL_FOLD:  nxt = fold_out;
            default:  nxt = '0;
        endcase
    end

    // next-state: quiet / accept / refuse
    always_comb begin
        if (!in_valid)   state_d = ST_IDLE;
        else if (bad_op) state_d = ST_REJECT;
        else             state_d = ST_COMMIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            idx_q <= '0;
        end else if (in_valid) begin
            res_q <= bad_op ? '0 : nxt;
            idx_q <= dst_idx;
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        illegal = 1'b0;
        wr_data = '0;
        wr_idx  = idx_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_COMMIT: begin
                wr_en   = 1'b1;
                wr_data = res_q;
            end
            ST_REJECT: illegal = 1'b1;
            default: ;
        endcase
    end

    // R2
    accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (wr_en ^ illegal));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !illegal));

    // R3
    addi_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_ADDI && !reverse) |=>
            ((wr_data - $past(imm_ext)) == $past(dst_val)));

    // R7
    rl_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_RL && !reverse) |=>
            ({wr_data[0], wr_data[DATA_W-1:1]} == $past(dst_val)));

    // R10
    alias_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == OP_SLLX || opcode == OP_SRAX) && a_idx == dst_idx)
            |=> (illegal && !wr_en));

    // R12
    idx_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (wr_idx == $past(dst_idx)));
endmodule

// File: tb/rxa_unit_tb.sv
module rxa_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, reverse = 1'b0;
    logic [4:0]  opcode = '0;
    logic [2:0]  dst_idx = '0, a_idx = '0, b_idx = '0;
    logic [11:0] dst_val = '0, a_val = '0, b_val = '0;
    logic [8:0]  imm = '0;
    logic        wr_en, illegal;
    logic [2:0]  wr_idx;
    logic [11:0] wr_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxa_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reverse(reverse),
        .opcode(opcode), .dst_idx(dst_idx), .a_idx(a_idx), .b_idx(b_idx),
        .dst_val(dst_val), .a_val(a_val), .b_val(b_val), .imm(imm),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit known(input logic [4:0] op);
        return op inside {5'b00001, 5'b00010, 5'b00100, 5'b00101, 5'b01001, 5'b01010,
                          5'b10000, 5'b10001, 5'b11000, 5'b11001, 5'b11100, 5'b11110};
    endfunction

    function automatic bit reads_a(input logic [4:0] op);
        return op inside {5'b11000, 5'b11001, 5'b10000, 5'b10001, 5'b11100, 5'b11110};
    endfunction

    function automatic bit reads_b(input logic [4:0] op);
        return op inside {5'b01001, 5'b01010, 5'b11000, 5'b11001};
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'b00001, 5'b01001: return "R3";
            5'b00010, 5'b01010: return "R5";
            5'b00100, 5'b00101: return "R7";
            5'b11100, 5'b11110: return "R8";
            5'b10000, 5'b10001, 5'b11000, 5'b11001: return "R6";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [11:0] model(input logic [4:0] op, input bit rev,
                                          input logic [11:0] d, a, b, input logic [8:0] im);
        logic [11:0] sx;
        sx = {{3{im[8]}}, im};
        case (op)
            5'b01001: return rev ? d - b : d + b;
            5'b00001: return rev ? d - sx : d + sx;
            5'b01010: return d ^ b;
            5'b00010: return d ^ sx;
            5'b11000: return d ^ (a & b);
            5'b11001: return d ^ (a | b);
            5'b10000: return d ^ (a & sx);
            5'b10001: return d ^ (a | sx);
            5'b00100: return rev ? {d[0], d[11:1]} : {d[10:0], d[11]};
            5'b00101: return rev ? {d[10:0], d[11]} : {d[0], d[11:1]};
            5'b11100: return d ^ {a[10:0], 1'b0};
            5'b11110: return d ^ {a[11], a[11:1]};
            default:  return 12'h000;
        endcase
    endfunction

    // drive one operation; sample the response half a cycle after the capturing edge
    task automatic run(input logic [4:0] op, input bit rev, input logic [2:0] di, ai, bi,
                       input logic [11:0] d, a, b, input logic [8:0] im,
                       output logic we, output logic ill, output logic [11:0] data, output logic [2:0] widx);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; reverse = rev;
        dst_idx = di; a_idx = ai; b_idx = bi;
        dst_val = d; a_val = a; b_val = b; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        we = wr_en; ill = illegal; data = wr_data; widx = wr_idx;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic we, ill;
        logic [11:0] data, fwd, back;
        logic [2:0] widx;
        logic [2:0] di, ai, bi;
        logic [11:0] d, a, b;
        logic [8:0] im;

        // R1 during and just after reset
        repeat (3) @(negedge clk);
        chk(!wr_en && !illegal && wr_data == 0, "R1 in reset", {wr_en, illegal, 2'b0, wr_data}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !illegal && wr_data == 0, "R1 after reset", {wr_en, illegal, 2'b0, wr_data}, 16'h0);

        // sweep every opcode, both directions, distinct registers
        for (int op = 0; op < 32; op++) begin
            for (int rv = 0; rv < 2; rv++) begin
                for (int t = 0; t < 20; t++) begin
                    di = 3'($urandom % 8);
                    ai = 3'((di + 1 + $urandom % 7) % 8);
                    bi = 3'((di + 1 + $urandom % 7) % 8);
                    d = 12'($urandom); a = 12'($urandom); b = 12'($urandom); im = 9'($urandom);
                    run(5'(op), rv[0], di, ai, bi, d, a, b, im, we, ill, data, widx);
                    if (known(5'(op))) begin
                        chk(we && !ill && data == model(5'(op), rv[0], d, a, b, im),
                            tag_of(5'(op)), {we, ill, 2'b0, data},
                            {4'b1000, model(5'(op), rv[0], d, a, b, im)});
                    end else begin
                        chk(!we && ill && data == 0, "R11 undefined opcode",
                            {we, ill, 2'b0, data}, 16'h4000);
                    end
                    chk(widx == di, "R12 index echo", {13'b0, widx}, {13'b0, di});
                end
            end
        end

        // R4: full immediate sweep, XORI into zero exposes the extension
        for (int k = 0; k < 512; k++) begin
            run(5'b00010, 1'b0, 3'd1, 3'd2, 3'd3, 12'h000, 12'h0, 12'h0, 9'(k), we, ill, data, widx);
            chk(data == {{3{k[8]}}, k[8:0]}, "R4 sign extension", {4'b0, data}, {4'b0, {3{k[8]}}, k[8:0]});
        end

        // R3 wrap corners
        run(5'b00001, 1'b0, 3'd0, 3'd1, 3'd2, 12'hFFF, 12'h0, 12'h0, 9'h001, we, ill, data, widx);
        chk(data == 12'h000, "R3 add wraps up", {4'b0, data}, 16'h0000);
        run(5'b00001, 1'b1, 3'd0, 3'd1, 3'd2, 12'h000, 12'h0, 12'h0, 9'h001, we, ill, data, widx);
        chk(data == 12'hFFF, "R3 subtract wraps down", {4'b0, data}, 16'h0FFF);
        run(5'b01001, 1'b0, 3'd4, 3'd1, 3'd2, 12'h800, 12'h0, 12'h800, 9'h0, we, ill, data, widx);
        chk(data == 12'h000, "R3 add carry dropped", {4'b0, data}, 16'h0000);

        // R9 forward then reverse restores the destination
        for (int op = 0; op < 32; op++) begin
            if (known(5'(op))) begin
                for (int t = 0; t < 30; t++) begin
                    d = 12'($urandom); a = 12'($urandom); b = 12'($urandom); im = 9'($urandom);
                    run(5'(op), 1'b0, 3'd5, 3'd6, 3'd7, d, a, b, im, we, ill, fwd, widx);
                    run(5'(op), 1'b1, 3'd5, 3'd6, 3'd7, fwd, a, b, im, we, ill, back, widx);
                    chk(back == d, "R9 round trip", {4'b0, back}, {4'b0, d});
                end
            end
        end

        // R10 aliased sources are refused
        for (int op = 0; op < 32; op++) begin
            if (reads_a(5'(op))) begin
                run(5'(op), 1'b0, 3'd3, 3'd3, 3'd6, 12'h5A5, 12'h5A5, 12'h0F0, 9'h1FF, we, ill, data, widx);
                chk(!we && ill && data == 0, "R10 A aliases dst", {we, ill, 2'b0, data}, 16'h4000);
            end
            if (reads_b(5'(op))) begin
                run(5'(op), 1'b1, 3'd2, 3'd6, 3'd2, 12'h123, 12'h456, 12'h123, 9'h0, we, ill, data, widx);
                chk(!we && ill && data == 0, "R10 B aliases dst", {we, ill, 2'b0, data}, 16'h4000);
            end
        end

        // R10: an aliased index is harmless for an operation that does not read that source
        run(5'b00001, 1'b0, 3'd2, 3'd2, 3'd2, 12'h010, 12'h0, 12'h0, 9'h005, we, ill, data, widx);
        chk(we && !ill && data == 12'h015, "R10 unread alias ignored", {we, ill, 2'b0, data}, 16'h8015);

        // R2: response lasts one cycle, idle cycle stays quiet
        run(5'b01010, 1'b0, 3'd1, 3'd2, 3'd3, 12'h00F, 12'h0, 12'h0F0, 9'h0, we, ill, data, widx);
        chk(we && !ill, "R2 response present", {14'b0, we, ill}, 16'h0002);
        @(negedge clk);
        chk(!wr_en && !illegal, "R2 idle after response", {14'b0, wr_en, illegal}, 16'h0000);
        run(5'b00111, 1'b0, 3'd1, 3'd2, 3'd3, 12'h0, 12'h0, 12'h0, 9'h0, we, ill, data, widx);
        chk(!we && ill, "R2 refused response", {14'b0, we, ill}, 16'h0001);
        @(negedge clk);
        chk(!wr_en && !illegal, "R2 idle after refusal", {14'b0, wr_en, illegal}, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule